// File: doc/BRIEF.md
# 2D Descriptor Transfer Sequencer

This block is the loop controller of one DMA channel. It takes a loaded descriptor (a kind, an X count and a Y count) and walks an X index and a Y index across the single element transfers that the descriptor stands for. It supports four kinds: single, one-dimensional row, two-dimensional grid, and byte-wise memory copy. Address generation and bus access belong to a separate datapath. That datapath receives a transfer request from this block and answers each finished element with a done strobe in the same cycle.

Three independent 2-bit granularity selectors shape the work. The trigger granularity sets how much work one input trigger releases. The other two set when a completion interrupt pulse and when an output trigger pulse are produced. A descriptor that has run to its end hands over to the next one through a load strobe. It can chain into that next descriptor without a fresh trigger. Before the hand-over, the block stops instead when the next pointer is zero or when the descriptor asks for the channel to be disabled.

Top module: `xy_loop_sequencer`

## Requirements
- R1: After reset, xferReq, irqPulse, trigOutPulse, disablePulse and descDone are low, xIdx and yIdx are zero, and the sequencer is idle.
- R2: cfgDescLoad captures the descriptor only when the sequencer is idle or waiting for its next descriptor. A load in any other state is ignored. A captured descriptor issues no request until a trigger is accepted. xferReq rises in the cycle after the clock edge at which cfgTrigIn was seen.
- R3: cfgKind encodes 0 = single, 1 = row, 2 = grid, 3 = memory copy. One descriptor performs the following numbers of element transfers (xferReq high with xferDone high): 1 for single, X+1 for row, (X+1)*(Y+1) for grid, and X+1 one-byte transfers for copy.
- R4: xIdx increments after each finished transfer. When xIdx is at its last value it wraps to zero and yIdx increments. Both indices are zero after a descriptor completes.
- R5: Granularity code 0 in cfgTrigGran releases exactly one transfer per trigger.
- R6: Trigger code 1 releases one X row, which is the whole descriptor for single and copy.
- R7: Trigger code 2 releases the whole remaining descriptor.
- R8: Trigger code 3 runs the whole descriptor. When the next descriptor is then loaded, it starts without a trigger.
- R9: irqPulse is a one-cycle pulse, high in the cycle of a finished transfer that qualifies under cfgIrqGran. Code 0 qualifies every transfer, 1 the last of each row, 2 the last of the descriptor, and 3 the last of a descriptor whose next pointer is zero.
- R10: trigOutPulse follows the same encoding, under cfgOutGran, independently of the interrupt.
- R11: descDone pulses with the last transfer of a descriptor. When cfgDisable was captured set, disablePulse pulses in that cycle and the sequencer returns to idle, whatever the next pointer holds.
- R12: When cfgNextZero was captured set and the descriptor completes, the sequencer returns to idle. Otherwise it waits for the next load. In both states cfgTrigIn has no effect.
- R13: A trigger that arrives while transfers are running is dropped. When the running grant ends, xferReq goes low and stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgDescLoad | input | 1 | Load strobe for the descriptor fields |
| cfgKind | input | 2 | Descriptor kind |
| cfgXCount | input | XW | X count (transfers per row minus one) |
| cfgYCount | input | YW | Y count (rows minus one, grid only) |
| cfgTrigGran | input | 2 | Work released per trigger |
| cfgIrqGran | input | 2 | Interrupt granularity |
| cfgOutGran | input | 2 | Output trigger granularity |
| cfgNextZero | input | 1 | Next pointer of this descriptor is zero |
| cfgDisable | input | 1 | Disable channel when this descriptor completes |
| cfgTrigIn | input | 1 | Input trigger |
| xferDone | input | 1 | Datapath finished the requested element |
| xferReq | output | 1 | Request for one element transfer |
| xIdx | output | XW | Current X index |
| yIdx | output | YW | Current Y index |
| irqPulse | output | 1 | Completion interrupt pulse |
| trigOutPulse | output | 1 | Output trigger pulse |
| disablePulse | output | 1 | Channel disable pulse |
| descDone | output | 1 | Descriptor completed, next may be loaded |

## Verification
A wrong loop counter shows up at the indices on the very next clock. It also shifts the row and descriptor boundaries, so the interrupt and output trigger pulses move to the wrong cycle within the same row. A wrong control state shows up as xferReq being high or low against the reference. This is visible one cycle after the trigger, the load or the finishing transfer that should have moved the state. Because the reference model is compared on every clock, such a fault is reported at its first visible cycle and not only in the transfer totals.

// File: rtl/xyseq_pkg.sv
package xyseq_pkg;

  typedef enum logic [1:0] {
    KIND_SINGLE = 2'd0,
    KIND_ROW    = 2'd1,
    KIND_GRID   = 2'd2,
    KIND_COPY   = 2'd3
  } descKind_e;

  typedef enum logic [1:0] {
    GRAN_ELEMENT = 2'd0,
    GRAN_ROW     = 2'd1,
    GRAN_DESC    = 2'd2,
    GRAN_LIST    = 2'd3
  } gran_e;

  // control -> datapath strobes
  typedef struct packed {
    logic load;
    logic step;
    logic clear;
  } seqStrobe_t;

endpackage

// File: rtl/xyseq_dpath.sv
module xyseq_dpath
  import xyseq_pkg::*;
#(
  parameter int XW = 8,
  parameter int YW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqStrobe_t    stb,
  input  logic [1:0]    kindIn,
  input  logic [XW-1:0] xCountIn,
  input  logic [YW-1:0] yCountIn,
  input  logic [1:0]    trigGranIn,
  input  logic [1:0]    irqGranIn,
  input  logic [1:0]    outGranIn,
  input  logic          nextZeroIn,
  input  logic          disableIn,
  output logic [1:0]    trigGran,
  output logic [1:0]    irqGran,
  output logic [1:0]    outGran,
  output logic          nextZero,
  output logic          disableAfter,
  output logic          rowEnd,
  output logic          descEnd,
  output logic [XW-1:0] xIdx,
  output logic [YW-1:0] yIdx
);

  logic [XW-1:0] xLim;
  logic [YW-1:0] yLim;

  // descriptor capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      xLim         <= '0;
      yLim         <= '0;
      trigGran     <= '0;
      irqGran      <= '0;
      outGran      <= '0;
      nextZero     <= 1'b0;
      disableAfter <= 1'b0;
    end else if (stb.load) begin
      xLim         <= (kindIn == KIND_SINGLE) ? '0 : xCountIn;
      yLim         <= (kindIn == KIND_GRID) ? yCountIn : '0;
      trigGran     <= trigGranIn;
      irqGran      <= irqGranIn;
      outGran      <= outGranIn;
      nextZero     <= nextZeroIn;
      disableAfter <= disableIn;
    end
  end

  assign rowEnd  = (xIdx == xLim);
  assign descEnd = rowEnd && (yIdx == yLim);

  // nested X/Y loop counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      xIdx <= '0;
      yIdx <= '0;
    end else if (stb.load || stb.clear) begin
      xIdx <= '0;
      yIdx <= '0;
    end else if (stb.step) begin
      if (rowEnd) begin
        xIdx <= '0;
        yIdx <= yIdx + 1'b1;
      end else begin
        xIdx <= xIdx + 1'b1;
      end
    end
  end

  // R4: indices stay inside the loop bounds
  a_r4_x_in_range: assert property (@(posedge clk) disable iff (!rstN)
    xIdx <= xLim);
  a_r4_y_in_range: assert property (@(posedge clk) disable iff (!rstN)
    yIdx <= yLim);
  // R4: completion returns both indices to zero
  a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> (xIdx == '0 && yIdx == '0));

endmodule

// File: rtl/xyseq_ctrl.sv
module xyseq_ctrl
  import xyseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       descLoad,
  input  logic       trigIn,
  input  logic       xferDone,
  input  logic [1:0] trigGran,
  input  logic [1:0] irqGran,
  input  logic [1:0] outGran,
  input  logic       nextZero,
  input  logic       disableAfter,
  input  logic       rowEnd,
  input  logic       descEnd,
  output seqStrobe_t stb,
  output logic       xferReq,
  output logic       irqPulse,
  output logic       trigOutPulse,
  output logic       disablePulse,
  output logic       descDone
);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_FETCH = 2'd3
  } seqState_e;

  seqState_e state, stateNxt;
  logic      chainNext, chainNxt;
  logic      fin;
  logic      grantEnd;

  assign fin     = (state == ST_RUN) && xferDone;
  assign xferReq = (state == ST_RUN);

  always_comb begin
    case (trigGran)
      GRAN_ELEMENT: grantEnd = 1'b1;
      GRAN_ROW:     grantEnd = rowEnd;
      default:      grantEnd = descEnd;
    endcase
  end

  // two event decoders sharing one encoding: 0 interrupt, 1 output trigger
  logic [1:0] evGran [2];
  logic [1:0] evFire;
  assign evGran[0] = irqGran;
  assign evGran[1] = outGran;

  for (genvar g = 0; g < 2; g++) begin : g_event
    always_comb begin
      case (evGran[g])
        GRAN_ELEMENT: evFire[g] = fin;
        GRAN_ROW:     evFire[g] = fin && rowEnd;
        GRAN_DESC:    evFire[g] = fin && descEnd;
        default:      evFire[g] = fin && descEnd && nextZero;
      endcase
    end
  end

  assign irqPulse     = evFire[0];
  assign trigOutPulse = evFire[1];
  assign descDone     = fin && descEnd;
  assign disablePulse = fin && descEnd && disableAfter;

  assign stb.load  = descLoad && (state == ST_IDLE || state == ST_FETCH);
  assign stb.step  = fin && !descEnd;
  assign stb.clear = fin && descEnd;

  always_comb begin
    stateNxt = state;
    chainNxt = chainNext;
    case (state)
      ST_IDLE:  if (descLoad) stateNxt = ST_ARMED;
      ST_FETCH: if (descLoad) stateNxt = chainNext ? ST_RUN : ST_ARMED;
      ST_ARMED: if (trigIn) stateNxt = ST_RUN;
      ST_RUN: begin
        if (xferDone) begin
          if (descEnd) begin
            chainNxt = (trigGran == GRAN_LIST);
            stateNxt = (disableAfter || nextZero) ? ST_IDLE : ST_FETCH;
          end else if (grantEnd) begin
            stateNxt = ST_ARMED;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      chainNext <= 1'b0;
    end else begin
      state     <= stateNxt;
      chainNext <= chainNxt;
    end
  end

  // R9: an interrupt only accompanies a finishing transfer
  a_r9_irq_on_done: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> (xferReq && xferDone));
  // R10: same for the output trigger
  a_r10_out_on_done: assert property (@(posedge clk) disable iff (!rstN)
    trigOutPulse |-> (xferReq && xferDone));
  // R11: disable sends the sequencer to idle
  a_r11_disable_idle: assert property (@(posedge clk) disable iff (!rstN)
    disablePulse |=> (state == ST_IDLE));
  // R5: element granularity stops after each transfer
  a_r5_one_per_trig: assert property (@(posedge clk) disable iff (!rstN)
    (fin && trigGran == GRAN_ELEMENT) |=> !xferReq);
  // R13: an armed sequencer without trigger issues nothing
  a_r13_armed_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARMED && !trigIn) |=> !xferReq);

endmodule

// File: rtl/xy_loop_sequencer.sv
module xy_loop_sequencer
  import xyseq_pkg::*;
#(
  parameter int XW = 8,
  parameter int YW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgDescLoad,
  input  logic [1:0]    cfgKind,
  input  logic [XW-1:0] cfgXCount,
  input  logic [YW-1:0] cfgYCount,
  input  logic [1:0]    cfgTrigGran,
  input  logic [1:0]    cfgIrqGran,
  input  logic [1:0]    cfgOutGran,
  input  logic          cfgNextZero,
  input  logic          cfgDisable,
  input  logic          cfgTrigIn,
  input  logic          xferDone,
  output logic          xferReq,
  output logic [XW-1:0] xIdx,
  output logic [YW-1:0] yIdx,
  output logic          irqPulse,
  output logic          trigOutPulse,
  output logic          disablePulse,
  output logic          descDone
);

  seqStrobe_t stb;
  logic [1:0] trigGran, irqGran, outGran;
  logic       nextZero, disableAfter, rowEnd, descEnd;

  xyseq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .descLoad     (cfgDescLoad),
    .trigIn       (cfgTrigIn),
    .xferDone     (xferDone),
    .trigGran     (trigGran),
    .irqGran      (irqGran),
    .outGran      (outGran),
    .nextZero     (nextZero),
    .disableAfter (disableAfter),
    .rowEnd       (rowEnd),
    .descEnd      (descEnd),
    .stb          (stb),
    .xferReq      (xferReq),
    .irqPulse     (irqPulse),
    .trigOutPulse (trigOutPulse),
    .disablePulse (disablePulse),
    .descDone     (descDone)
  );

  xyseq_dpath #(.XW(XW), .YW(YW)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .kindIn       (cfgKind),
    .xCountIn     (cfgXCount),
    .yCountIn     (cfgYCount),
    .trigGranIn   (cfgTrigGran),
    .irqGranIn    (cfgIrqGran),
    .outGranIn    (cfgOutGran),
    .nextZeroIn   (cfgNextZero),
    .disableIn    (cfgDisable),
    .trigGran     (trigGran),
    .irqGran      (irqGran),
    .outGran      (outGran),
    .nextZero     (nextZero),
    .disableAfter (disableAfter),
    .rowEnd       (rowEnd),
    .descEnd      (descEnd),
    .xIdx         (xIdx),
    .yIdx         (yIdx)
  );

endmodule

// File: tb/xy_loop_sequencer_bench.sv
module xy_loop_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int XW = 8;
  localparam int YW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgDescLoad = 0, cfgNextZero = 0, cfgDisable = 0, cfgTrigIn = 0, xferDone = 0;
  logic [1:0] cfgKind = 0, cfgTrigGran = 0, cfgIrqGran = 0, cfgOutGran = 0;
  logic [XW-1:0] cfgXCount = 0;
  logic [YW-1:0] cfgYCount = 0;
  logic xferReq, irqPulse, trigOutPulse, disablePulse, descDone;
  logic [XW-1:0] xIdx;
  logic [YW-1:0] yIdx;

  always #(CLK_PERIOD/2) clk = ~clk;

  xy_loop_sequencer #(.XW(XW), .YW(YW)) u_xy_loop_sequencer (.*);

  int checks = 0, errors = 0, cyc = 0;
  int tally = 0, irqTally = 0, outTally = 0, disTally = 0;
  bit modelOn = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 armed, 2 running, 3 awaiting next
  int ph = 0, done = 0, cred = 0, total = 1, xw = 1;
  int mKind = 0, mXc = 0, mYc = 0, mTm = 0, mIm = 0, mOm = 0;
  bit mNz = 0, mDis = 0, mChain = 0;

  task automatic latchDesc();
    mKind = cfgKind; mXc = cfgXCount; mYc = cfgYCount;
    mTm = cfgTrigGran; mIm = cfgIrqGran; mOm = cfgOutGran;
    mNz = cfgNextZero; mDis = cfgDisable;
    xw = (mKind == 0) ? 1 : mXc + 1;
    total = xw * ((mKind == 2) ? mYc + 1 : 1);
    done = 0;
  endtask

  function automatic int grantSize();
    if (mTm == 0) return 1;
    if (mTm == 1) return xw;
    return total - done;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      ph = 0; done = 0; cred = 0; mChain = 0; xw = 1; total = 1;
    end else begin
      if (xferReq && xferDone) tally++;
      if (irqPulse) irqTally++;
      if (trigOutPulse) outTally++;
      if (disablePulse) disTally++;
      case (ph)
        0: if (cfgDescLoad) begin latchDesc(); ph = 1; end
        3: if (cfgDescLoad) begin
             latchDesc();
             if (mChain) begin ph = 2; cred = grantSize(); end else ph = 1;
           end
        1: if (cfgTrigIn) begin ph = 2; cred = grantSize(); end
        default: if (xferDone) begin
             done++; cred--;
             if (done == total) begin
               mChain = (mTm == 3);
               ph = (mDis || mNz) ? 0 : 3;
               done = 0;
             end else if (cred == 0) ph = 1;
           end
      endcase
    end
  end

  function automatic bit fires(int g, bit rowE, bit descE);
    case (g)
      0: return 1'b1;
      1: return rowE;
      2: return descE;
      default: return descE && mNz;
    endcase
  endfunction

  always @(negedge clk) begin
    if (modelOn) begin
      bit evt, rowE, descE;
      evt   = (ph == 2) && xferDone;
      rowE  = ((done + 1) % xw) == 0;
      descE = (done + 1) == total;
      chk("R3 xferReq", int'(xferReq), int'(ph == 2));
      chk("R4 xIdx", int'(xIdx), done % xw);
      chk("R4 yIdx", int'(yIdx), done / xw);
      chk("R9 irqPulse", int'(irqPulse), int'(evt && fires(mIm, rowE, descE)));
      chk("R10 trigOutPulse", int'(trigOutPulse), int'(evt && fires(mOm, rowE, descE)));
      chk("R11 descDone", int'(descDone), int'(evt && descE));
      chk("R11 disablePulse", int'(disablePulse), int'(evt && descE && mDis));
    end
  end

  task automatic tick();
    @(negedge clk); #1;
    cyc++;
    xferDone = xferReq && ((cyc % 3) != 0);
  endtask

  task automatic setDesc(int k, int xc, int yc, int tm, int im, int om, bit nz, bit dis);
    cfgKind = 2'(k); cfgXCount = XW'(xc); cfgYCount = YW'(yc);
    cfgTrigGran = 2'(tm); cfgIrqGran = 2'(im); cfgOutGran = 2'(om);
    cfgNextZero = nz; cfgDisable = dis;
  endtask

  task automatic loadDesc(int k, int xc, int yc, int tm, int im, int om, bit nz, bit dis);
    setDesc(k, xc, yc, tm, im, om, nz, dis);
    cfgDescLoad = 1; tick(); cfgDescLoad = 0;
  endtask

  task automatic drain();
    for (int n = 0; n < 400 && xferReq; n++) tick();
  endtask

  task automatic fire(string tag, int expN);
    int t0;
    t0 = tally;
    cfgTrigIn = 1; tick(); cfgTrigIn = 0;
    drain();
    chk(tag, tally - t0, expN);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t0, i0, o0, d0;
    repeat (3) tick();
    rstN = 1; tick();
    // R1 reset state
    chk("R1 xferReq", int'(xferReq), 0);
    chk("R1 xIdx", int'(xIdx), 0);
    chk("R1 yIdx", int'(yIdx), 0);
    chk("R1 pulses", int'(irqPulse | trigOutPulse | disablePulse | descDone), 0);
    modelOn = 1;

    // grid 3x2, one transfer per trigger, irq per row, out per element
    loadDesc(2, 2, 1, 0, 1, 0, 1'b1, 1'b0);
    repeat (3) tick();
    chk("R2 no request before trigger", int'(xferReq), 0);
    t0 = tally; i0 = irqTally; o0 = outTally;
    for (int k = 0; k < 6; k++) fire("R5 one transfer per trigger", 1);
    chk("R3 grid total", tally - t0, 6);
    chk("R9 irq per row", irqTally - i0, 2);
    chk("R10 out per element", outTally - o0, 6);
    // R12: idle after zero next pointer, trigger ignored
    t0 = tally;
    cfgTrigIn = 1; tick(); cfgTrigIn = 0; repeat (3) tick();
    chk("R12 idle ignores trigger", tally - t0, 0);

    // row of 4, row granularity, irq per descriptor, out on list end (next nonzero)
    loadDesc(1, 3, 0, 1, 2, 3, 1'b0, 1'b0);
    i0 = irqTally; o0 = outTally;
    fire("R6 row trigger on row", 4);
    chk("R9 irq per descriptor", irqTally - i0, 1);
    chk("R10 list end not reached", outTally - o0, 0);
    t0 = tally;
    cfgTrigIn = 1; tick(); cfgTrigIn = 0; repeat (3) tick();
    chk("R12 awaiting next ignores trigger", tally - t0, 0);

    // grid 4x2, row granularity, trigger dropped while running
    loadDesc(2, 3, 1, 1, 0, 1, 1'b0, 1'b0);
    t0 = tally;
    cfgTrigIn = 1; tick(); cfgTrigIn = 0; tick(); tick();
    cfgTrigIn = 1; tick(); cfgTrigIn = 0;
    drain(); repeat (3) tick();
    chk("R13 extra trigger dropped", tally - t0, 4);
    chk("R13 request stays low", int'(xferReq), 0);
    fire("R6 second row", 4);

    // grid 2x3, whole descriptor per trigger
    loadDesc(2, 1, 2, 2, 3, 2, 1'b0, 1'b0);
    i0 = irqTally; o0 = outTally;
    fire("R7 descriptor per trigger", 6);
    chk("R9 list-end irq not due", irqTally - i0, 0);
    chk("R10 out per descriptor", outTally - o0, 1);

    // single with chain granularity; a load while armed is ignored
    loadDesc(0, 5, 0, 3, 2, 2, 1'b0, 1'b0);
    loadDesc(3, 9, 0, 2, 0, 0, 1'b0, 1'b1);
    fire("R2 load while armed ignored", 1);

    // chained row of 2 starts without trigger
    t0 = tally;
    loadDesc(1, 1, 0, 2, 2, 2, 1'b0, 1'b0);
    drain();
    chk("R8 chained start without trigger", tally - t0, 2);

    // copy of 5 bytes with disable
    loadDesc(3, 4, 0, 1, 1, 2, 1'b0, 1'b1);
    i0 = irqTally; o0 = outTally; d0 = disTally;
    fire("R3 copy byte count", 5);
    chk("R6 copy is one row irq", irqTally - i0, 1);
    chk("R11 disable pulse", disTally - d0, 1);
    t0 = tally;
    cfgTrigIn = 1; tick(); cfgTrigIn = 0; repeat (3) tick();
    chk("R11 idle after disable", tally - t0, 0);
    loadDesc(0, 0, 0, 0, 3, 3, 1'b1, 1'b0);
    i0 = irqTally; o0 = outTally;
    fire("R11 reload after disable", 1);
    chk("R9 irq at list end", irqTally - i0, 1);
    chk("R10 out at list end", outTally - o0, 1);
    repeat (3) tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule